// File: doc/BRIEF.md
# Control Packet Receive Queue

This block keeps track of control packets that have already been written into a shared row memory, so that a local processor can take them out one at a time in arrival order. Each arrival carries the start row of its packet. The block stores that row in an ordered address queue, counts the packets that are still waiting, and raises an interrupt.

The processor works through a small command port. It copies the oldest start row into a row pointer, which leaves the queue unchanged. It can set the pointer directly. It fetches rows one per read command, and the pointer steps forward after each fetch. When it has read the whole packet it releases the entry with a separate command. The pending count tells it whether to run the service loop again. Rows reach the memory through a plain write port on the receive side.

A two-state controller handles the commands. In `S_IDLE` it takes any command. A row read moves it to `S_CAPTURE` (transition IDLE→CAPTURE), where the registered memory output is latched into the row data register and the pointer is incremented. It then returns unconditionally (transition CAPTURE→IDLE). While the controller is in `S_CAPTURE`, commands are dropped.

Top module: `cpq_rx_queue`

## Requirements
- R1: After reset `pend_count` is 0, and `irq`, `ovf_flag`, `free_err`, `cmd_busy`, `row_addr` and `row_data` are all 0.
- R2: A `pkt_valid` pulse with `pend_count` below 8 stores `pkt_start` and raises `pend_count` by 1 at that clock edge. Stored addresses come back out in arrival order.
- R3: A `pkt_valid` pulse with `pend_count` equal to 8 is dropped and `pend_count` stays 8. `ovf_flag` goes to 1 and stays at 1 until reset.
- R4: Command op 1 (load head) copies the oldest queued address into `row_addr` at the next edge. `pend_count` does not change.
- R5: Command op 3 (free head) removes the oldest entry and lowers `pend_count` by 1. The next load head then returns the following address.
- R6: Op 3 issued when `pend_count` is 0 leaves the count at 0. It sets `free_err`, which stays at 1 until reset.
- R7: Command op 2 (read row) makes `cmd_busy` 1 after one edge. After the second edge, `row_data` holds the memory row at the old `row_addr`, `row_addr` has risen by 1 and `cmd_busy` is 0.
- R8: Command op 4 (set row) loads `cmd_arg` into `row_addr`.
- R9: A stored arrival sets `irq`. `irq` stays 1 whenever `pend_count` is nonzero, even if an acknowledge is sent.
- R10: Command op 5 (acknowledge) clears `irq` only when `cmd_arg[0]` is 1 and `pend_count` is 0. With `cmd_arg[0]` at 0 it has no effect.
- R11: A command presented while `cmd_busy` is 1 is ignored.
- R12: `mem_we` writes `mem_wdata` to row `mem_waddr`, and a later read row returns that data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | A packet has been stored in memory |
| pkt_start | input | 6 | Start row of that packet |
| mem_we | input | 1 | Row write strobe from the receive side |
| mem_waddr | input | 6 | Row to write |
| mem_wdata | input | 32 | Row data to write |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (1 load head, 2 read row, 3 free head, 4 set row, 5 acknowledge) |
| cmd_arg | input | 6 | Command argument |
| cmd_busy | output | 1 | A row read is in progress |
| row_addr | output | 6 | Row pointer |
| row_data | output | 32 | Last row fetched |
| pend_count | output | 4 | Packets waiting |
| irq | output | 1 | Packet-received interrupt |
| ovf_flag | output | 1 | Sticky flag: an arrival was dropped |
| free_err | output | 1 | Sticky flag: free head was issued on an empty queue |

## Verification
Some rules are checked by assertions on every cycle:
- the count never goes past the queue depth;
- a drop leaves the count unchanged;
- the interrupt is high whenever packets are waiting;
- both error flags are sticky;
- a read always enters the busy state;
- load head copies the current head.

Other behaviour can only be shown by the bench's scenarios. These are:
- arrival order surviving a full fill and drain;
- the data returned for a row actually written;
- commands dropped while busy;
- an acknowledge whose argument bit is 0.

// File: rtl/cpq_pkg.sv
package cpq_pkg;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_LOAD_HEAD = 3'd1,
        OP_READ_ROW  = 3'd2,
        OP_FREE_HEAD = 3'd3,
        OP_SET_ROW   = 3'd4,
        OP_ACK_IRQ   = 3'd5
    } cpq_op_e;

    typedef enum logic {
        S_IDLE    = 1'b0,
        S_CAPTURE = 1'b1
    } cpq_state_e;

endpackage

// File: rtl/cpq_addr_fifo.sv
module cpq_addr_fifo #(
    parameter int DEPTH = 8,
    parameter int AW    = 6,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [AW-1:0] push_addr,
    input  logic          pop_req,
    output logic [AW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [AW-1:0] slots [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push_req && !full;
    assign do_pop  = pop_req && !empty;
    assign head    = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) slots[wr_ptr] <= push_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R3
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && !pop_req) |=> $stable(count)); // R3

endmodule

// File: rtl/cpq_row_mem.sv
module cpq_row_mem #(
    parameter int AW    = 6,
    parameter int ROW_W = 32,
    localparam int ROWS = 1 << AW
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [ROW_W-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [ROW_W-1:0] rdata
);
    logic [ROW_W-1:0] rows [ROWS];

    always_ff @(posedge clk) begin
        if (we) rows[waddr] <= wdata;
        if (re) rdata <= rows[raddr];
    end

endmodule

// File: rtl/cpq_cmd_fsm.sv
module cpq_cmd_fsm
    import cpq_pkg::*;
#(
    parameter int AW    = 6,
    parameter int ROW_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [AW-1:0]    cmd_arg,
    input  logic [AW-1:0]    head_addr,
    input  logic             q_empty,
    input  logic [ROW_W-1:0] rd_data,
    output logic             pop,
    output logic             rd_en,
    output logic [AW-1:0]    rd_addr,
    output logic [AW-1:0]    row_addr,
    output logic [ROW_W-1:0] row_data,
    output logic             busy,
    output logic             free_err
);
    cpq_state_e state_q, state_d;
    cpq_op_e    op;
    logic       accept;

    assign op     = cpq_op_e'(cmd_op);
    assign accept = cmd_valid && (state_q == S_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (accept && op == OP_READ_ROW) state_d = S_CAPTURE;
            S_CAPTURE: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_comb begin
        pop     = accept && (op == OP_FREE_HEAD) && !q_empty;
        rd_en   = accept && (op == OP_READ_ROW);
        rd_addr = row_addr;
        busy    = (state_q == S_CAPTURE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_addr <= '0;
            row_data <= '0;
            free_err <= 1'b0;
        end else begin
            if (state_q == S_CAPTURE) begin
                row_data <= rd_data;
                row_addr <= row_addr + 1'b1;
            end else if (accept && op == OP_LOAD_HEAD) begin
                row_addr <= head_addr;
            end else if (accept && op == OP_SET_ROW) begin
                row_addr <= cmd_arg;
            end
            if (accept && op == OP_FREE_HEAD && q_empty) free_err <= 1'b1;
        end
    end

    AST_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_READ_ROW) |=> busy); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        free_err |=> free_err); // R6
    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_LOAD_HEAD) |=> (row_addr == $past(head_addr))); // R4

endmodule

// File: rtl/cpq_rx_queue.sv
module cpq_rx_queue
    import cpq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 6,
    parameter int ROW_W = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_valid,
    input  logic [AW-1:0]    pkt_start,
    input  logic             mem_we,
    input  logic [AW-1:0]    mem_waddr,
    input  logic [ROW_W-1:0] mem_wdata,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [AW-1:0]    cmd_arg,
    output logic             cmd_busy,
    output logic [AW-1:0]    row_addr,
    output logic [ROW_W-1:0] row_data,
    output logic [CW-1:0]    pend_count,
    output logic             irq,
    output logic             ovf_flag,
    output logic             free_err
);
    logic [AW-1:0]    head;
    logic             q_full, q_empty, pop;
    logic             rd_en;
    logic [AW-1:0]    rd_addr;
    logic [ROW_W-1:0] rd_data;
    logic             stored, ack_clear;

    cpq_addr_fifo #(.DEPTH(DEPTH), .AW(AW)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_req(pkt_valid), .push_addr(pkt_start), .pop_req(pop),
        .head(head), .count(pend_count), .full(q_full), .empty(q_empty)
    );

    cpq_row_mem #(.AW(AW), .ROW_W(ROW_W)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .re(rd_en), .raddr(rd_addr), .rdata(rd_data)
    );

    cpq_cmd_fsm #(.AW(AW), .ROW_W(ROW_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
        .head_addr(head), .q_empty(q_empty), .rd_data(rd_data),
        .pop(pop), .rd_en(rd_en), .rd_addr(rd_addr),
        .row_addr(row_addr), .row_data(row_data),
        .busy(cmd_busy), .free_err(free_err)
    );

    assign stored    = pkt_valid && !q_full;
    assign ack_clear = cmd_valid && !cmd_busy && (cmd_op == OP_ACK_IRQ)
                       && cmd_arg[0] && q_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq      <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            irq <= stored || (irq && !ack_clear);
            if (pkt_valid && q_full) ovf_flag <= 1'b1;
        end
    end

    AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_count != '0) |-> irq); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag); // R3

endmodule

// File: tb/cpq_rx_queue_tb.sv
module cpq_rx_queue_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pkt_valid;
    logic [5:0]  pkt_start;
    logic        mem_we;
    logic [5:0]  mem_waddr;
    logic [31:0] mem_wdata;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [5:0]  cmd_arg;
    logic        cmd_busy;
    logic [5:0]  row_addr;
    logic [31:0] row_data;
    logic [3:0]  pend_count;
    logic        irq, ovf_flag, free_err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cpq_rx_queue u_dut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_start(pkt_start),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
        .cmd_busy(cmd_busy), .row_addr(row_addr), .row_data(row_data),
        .pend_count(pend_count), .irq(irq), .ovf_flag(ovf_flag), .free_err(free_err)
    );

    // vector: pv, start, cv, op, arg, exp count, exp row_addr, exp irq
    localparam int NV = 14;
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 6'd10, 1'b0, 3'd0, 6'd0,  4'd1, 6'd0,  1'b1}, // R2 R9
        {1'b1, 6'd20, 1'b0, 3'd0, 6'd0,  4'd2, 6'd0,  1'b1}, // R2
        {1'b1, 6'd30, 1'b0, 3'd0, 6'd0,  4'd3, 6'd0,  1'b1}, // R2
        {1'b0, 6'd0,  1'b1, 3'd1, 6'd0,  4'd3, 6'd10, 1'b1}, // R4
        {1'b0, 6'd0,  1'b1, 3'd3, 6'd0,  4'd2, 6'd10, 1'b1}, // R5
        {1'b0, 6'd0,  1'b1, 3'd1, 6'd0,  4'd2, 6'd20, 1'b1}, // R5
        {1'b0, 6'd0,  1'b1, 3'd5, 6'd1,  4'd2, 6'd20, 1'b1}, // R9 ack held
        {1'b0, 6'd0,  1'b1, 3'd3, 6'd0,  4'd1, 6'd20, 1'b1}, // R5
        {1'b0, 6'd0,  1'b1, 3'd1, 6'd0,  4'd1, 6'd30, 1'b1}, // R4
        {1'b0, 6'd0,  1'b1, 3'd3, 6'd0,  4'd0, 6'd30, 1'b1}, // R5
        {1'b0, 6'd0,  1'b1, 3'd5, 6'd0,  4'd0, 6'd30, 1'b1}, // R10 bit0 low
        {1'b0, 6'd0,  1'b1, 3'd5, 6'd1,  4'd0, 6'd30, 1'b0}, // R10 clears
        {1'b0, 6'd0,  1'b1, 3'd4, 6'd5,  4'd0, 6'd5,  1'b0}, // R8
        {1'b1, 6'd7,  1'b0, 3'd0, 6'd0,  4'd1, 6'd5,  1'b1}  // R9
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        pkt_valid = 0; pkt_start = 0; mem_we = 0; mem_waddr = 0; mem_wdata = 0;
        cmd_valid = 0; cmd_op = 0; cmd_arg = 0;
    endtask

    task automatic cmd(input logic [2:0] op, input logic [5:0] arg);
        cmd_valid = 1; cmd_op = op; cmd_arg = arg;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic arrive(input logic [5:0] a);
        pkt_valid = 1; pkt_start = a;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic memwr(input logic [5:0] a, input logic [31:0] d);
        mem_we = 1; mem_waddr = a; mem_wdata = d;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=%0d expected=<20000", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", pend_count, 0);
        chk("R1 irq", irq, 0);
        chk("R1 ovf", ovf_flag, 0);
        chk("R1 err", free_err, 0);
        chk("R1 busy", cmd_busy, 0);
        chk("R1 row_addr", row_addr, 0);
        chk("R1 row_data", row_data, 0);

        for (int i = 0; i < NV; i++) begin
            {pkt_valid, pkt_start, cmd_valid, cmd_op, cmd_arg} = VEC[i][27:11];
            @(negedge clk);
            idle_inputs();
            chk($sformatf("table[%0d] count", i), pend_count, VEC[i][10:7]);
            chk($sformatf("table[%0d] row_addr", i), row_addr, VEC[i][6:1]);
            chk($sformatf("table[%0d] irq", i), irq, VEC[i][0]);
        end

        // R3: fill to depth, then one dropped arrival
        for (int i = 0; i < 7; i++) arrive(6'(40 + i));
        chk("R3 full count", pend_count, 8);
        chk("R3 ovf before", ovf_flag, 0);
        arrive(6'd63);
        chk("R3 drop count", pend_count, 8);
        chk("R3 ovf set", ovf_flag, 1);

        // R2 order preserved through full drain
        for (int i = 0; i < 8; i++) begin
            cmd(3'd1, 0);
            chk("R2 order", row_addr, (i == 0) ? 32'd7 : 32'(40 + i - 1));
            cmd(3'd3, 0);
            chk("R5 drain count", pend_count, 32'(7 - i));
        end
        chk("R9 irq unacked", irq, 1);
        chk("R3 ovf sticky", ovf_flag, 1);

        // R6 free on empty
        chk("R6 err before", free_err, 0);
        cmd(3'd3, 0);
        chk("R6 count", pend_count, 0);
        chk("R6 err set", free_err, 1);

        // R12 / R7 / R11 row fetch
        memwr(6'd12, 32'hA5C3_0F12);
        memwr(6'd13, 32'h5A3C_F013);
        cmd(3'd4, 6'd12);
        chk("R8 set row", row_addr, 12);
        cmd_valid = 1; cmd_op = 3'd2; cmd_arg = 0;
        @(negedge clk);
        chk("R7 busy", cmd_busy, 1);
        cmd_op = 3'd4; cmd_arg = 6'd50;   // ignored while busy
        @(negedge clk);
        idle_inputs();
        chk("R7 busy done", cmd_busy, 0);
        chk("R12 row data", row_data, 32'hA5C3_0F12);
        chk("R11 row_addr", row_addr, 13);
        @(negedge clk);
        chk("R11 no late set", row_addr, 13);
        cmd(3'd2, 0);
        @(negedge clk);
        chk("R12 second row", row_data, 32'h5A3C_F013);
        chk("R7 increment", row_addr, 14);
        chk("R6 err sticky", free_err, 1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule